// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Scheduler

This block keeps a 1024-row asynchronous DRAM refreshed and brings it through its start-up sequence. After reset it holds the memory untouched for a programmable pause. It then asks the access sequencer for the bus and issues a burst of initialization refresh cycles. Only after that burst does it raise its ready flag. From then on, an interval timer marks each point at which one refresh is due. The block requests the bus and, once granted, drives refresh cycles in which CAS is asserted ahead of RAS. In this ordering the memory takes the row from its own internal counter, so no address is driven.

Intervals that expire while the bus is withheld are stored in a pending counter. That counter is drained back to back as soon as the grant arrives, and it is capped at a limit. A sticky flag records any interval that is lost because the counter is already at the limit. A parameter selects one of two policies: request the bus as soon as one refresh is owed, or wait until a group of refreshes has collected and then drain the whole group. If no refresh completes for a long stretch, the ready flag drops and the initialization burst is repeated. The strobes stay high whenever the grant is absent.

All timings are counted in clock cycles, and each one is a parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset, ras_n, cas_lo_n, cas_hi_n and we_n are 1, and ref_req, init_done and pend_ovf are 0.
- R2: No strobe is asserted during the first PAUSE_CYC cycles after reset is released. The first RAS fall follows within a few cycles after that pause.
- R3: After the pause, exactly INIT_CYCLES refresh cycles are issued before init_done rises. init_done is never 1 before the last of them has started.
- R4: In every refresh cycle, both CAS lines fall together and stay low for exactly CSR_CYC cycles before RAS falls. They stay low for exactly CHR_CYC cycles from the RAS fall, and cas_lo_n always equals cas_hi_n.
- R5: RAS stays low for exactly RAS_LOW_CYC cycles. Between two refresh cycles, RAS stays high for at least PRE_CYC + CSR_CYC cycles.
- R6: we_n is 1 at all times.
- R7: With the distributed policy (BURST_MODE = 0) and the grant held, exactly one refresh cycle is issued per REF_INTERVAL_CYC cycles.
- R8: While ref_gnt is 0, ras_n, cas_lo_n and cas_hi_n are all 1.
- R9: Intervals that expire without a grant are counted. ref_req stays 1 while any refresh is owed, the owed cycles run back to back once the grant arrives, and ref_req then returns to 0.
- R10: The owed count never exceeds PEND_MAX. An interval that expires while the count is at PEND_MAX sets pend_ovf, which then stays 1 until reset.
- R11: With the grouped policy (BURST_MODE = 1), ref_req rises only when BURST_LEN refreshes are owed. A whole group then runs back to back, so consecutive RAS falls are either one refresh cycle apart or BURST_LEN intervals minus the group length apart.
- R12: If no refresh cycle completes for IDLE_LIMIT_CYC cycles while ready, init_done drops and the owed count is cleared. INIT_CYCLES refresh cycles are then issued with no pause, and init_done returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_req | output | 1 | Request for the DRAM bus |
| ref_gnt | input | 1 | Bus granted by the access sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held inactive |
| init_done | output | 1 | Start-up sequence complete, host access allowed |
| pend_ovf | output | 1 | Sticky flag: a refresh was lost at the cap |

## Verification
The bench builds two small instances: one with the distributed policy and one with the grouped policy and BURST_LEN of 3. Both use a 100-cycle pause, a 60-cycle interval, two- to four-cycle strobe phases, a cap of 4 and an idle limit of 600 cycles. These short settings let one run cover the whole start-up, ten steady intervals, a drain of two owed refreshes, saturation with overflow, and a re-initialization after idling. Every strobe edge is timed against the parameter values. The expected refresh counts and RAS fall spacings are computed from the interval and cycle lengths.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_READY} phase_e;
   typedef enum logic [1:0] {CG_IDLE, CG_SETUP, CG_ACT, CG_PRE} cg_state_e;
endpackage

// File: rtl/rfs_cbr_gen.sv
// Generates one CAS-before-RAS cycle per start pulse.
module rfs_cbr_gen
   import rfs_pkg::*;
#(
   parameter int CSR_CYC     = 1,
   parameter int RAS_LOW_CYC = 5,
   parameter int CHR_CYC     = 1,
   parameter int PRE_CYC     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic ras_act,
   output logic cas_act
);
   localparam int SPAN_A = (CSR_CYC > RAS_LOW_CYC) ? CSR_CYC : RAS_LOW_CYC;
   localparam int SPAN   = (SPAN_A > PRE_CYC) ? SPAN_A : PRE_CYC;
   localparam int CW     = $clog2(SPAN + 1);
   localparam logic [CW-1:0] SETUP_LAST = CW'(CSR_CYC - 1);
   localparam logic [CW-1:0] ACT_LAST   = CW'(RAS_LOW_CYC - 1);
   localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);
   localparam logic [CW-1:0] HOLD_END   = CW'(CHR_CYC);

   cg_state_e       state_q, state_d;
   logic [CW-1:0]   cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + CW'(1);
      unique case (state_q)
         CG_IDLE: begin
            cnt_d = '0;
            if (start) state_d = CG_SETUP;
         end
         CG_SETUP: begin
            if (cnt_q == SETUP_LAST) begin
               state_d = CG_ACT;
               cnt_d   = '0;
            end
         end
         CG_ACT: begin
            if (cnt_q == ACT_LAST) begin
               state_d = CG_PRE;
               cnt_d   = '0;
            end
         end
         CG_PRE: begin
            if (cnt_q == PRE_LAST) begin
               state_d = CG_IDLE;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = CG_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CG_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy    = (state_q != CG_IDLE);
   assign done    = (state_q == CG_PRE) && (cnt_q == PRE_LAST);
   assign ras_act = (state_q == CG_ACT);
   assign cas_act = (state_q == CG_SETUP) || ((state_q == CG_ACT) && (cnt_q < HOLD_END));

   // R4: CAS already low on the cycle before RAS becomes active
   a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_act) |-> (cas_act && $past(cas_act)));
   // R4: CAS released before RAS ends
   a_r4_cas_off_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_act) |-> !cas_act);
   // R5: a new cycle is only launched from idle
   a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/rfs_interval_tick.sv
// Free-running interval timer, held at zero while disabled.
module rfs_interval_tick #(
   parameter int REF_INTERVAL_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int IW = $clog2(REF_INTERVAL_CYC + 1);
   localparam logic [IW-1:0] LAST = IW'(REF_INTERVAL_CYC - 1);

   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en)          cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + IW'(1);
   end

   assign tick = en && (cnt_q == LAST);

   // R7: interval expiries are never adjacent
   a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/rfs_pending.sv
// Owed-refresh counter with cap, sticky overflow and request policy.
module rfs_pending #(
   parameter int PEND_MAX   = 8,
   parameter int BURST_MODE = 0,
   parameter int BURST_LEN  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   input  logic clr,
   output logic want,
   output logic empty,
   output logic ovf
);
   localparam int PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

   logic [PW-1:0] pend_q;
   logic          ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         ovf_q  <= 1'b0;
      end else if (clr) begin
         pend_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10: begin
               if (pend_q == CAP) ovf_q  <= 1'b1;
               else               pend_q <= pend_q + PW'(1);
            end
            2'b01: begin
               if (pend_q != '0) pend_q <= pend_q - PW'(1);
            end
            default: ;
         endcase
      end
   end

   generate
      if (BURST_MODE != 0) begin : g_grouped
         localparam logic [PW-1:0] THRESH = PW'(BURST_LEN);
         logic drain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   drain_q <= 1'b0;
            else if (clr) drain_q <= 1'b0;
            else          drain_q <= (pend_q >= THRESH) || (drain_q && (pend_q != '0));
         end
         assign want = (drain_q && (pend_q != '0)) || (pend_q >= THRESH);
      end else begin : g_spread
         assign want = (pend_q != '0);
      end
   endgenerate

   assign empty = (pend_q == '0);
   assign ovf   = ovf_q;

   a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= CAP);
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
   a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> ($past(inc) && ($past(pend_q) == CAP)));
endmodule

// File: rtl/rfs_phase_ctl.sv
// Start-up pause, initialization burst and idle watch.
module rfs_phase_ctl
   import rfs_pkg::*;
#(
   parameter int PAUSE_CYC      = 20000,
   parameter int INIT_CYCLES    = 8,
   parameter int IDLE_LIMIT_CYC = 800000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cyc_start,
   input  logic   cyc_done,
   output phase_e phase,
   output logic   reinit
);
   localparam int AW = $clog2(PAUSE_CYC + 1);
   localparam int NW = $clog2(INIT_CYCLES + 1);
   localparam int DW = $clog2(IDLE_LIMIT_CYC + 1);
   localparam logic [AW-1:0] PAUSE_LAST = AW'(PAUSE_CYC - 1);
   localparam logic [NW-1:0] INIT_LAST  = NW'(INIT_CYCLES - 1);
   localparam logic [DW-1:0] IDLE_LAST  = DW'(IDLE_LIMIT_CYC - 1);

   phase_e        phase_q;
   logic [AW-1:0] pause_q;
   logic [NW-1:0] init_q;
   logic [DW-1:0] idle_q;

   assign reinit = (phase_q == PH_READY) && !cyc_done && (idle_q == IDLE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PAUSE;
         pause_q <= '0;
         init_q  <= '0;
         idle_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_PAUSE: begin
               if (pause_q == PAUSE_LAST) phase_q <= PH_INIT;
               else                       pause_q <= pause_q + AW'(1);
            end
            PH_INIT: begin
               idle_q <= '0;
               if (cyc_done) begin
                  if (init_q == INIT_LAST) begin
                     phase_q <= PH_READY;
                     init_q  <= '0;
                  end else begin
                     init_q <= init_q + NW'(1);
                  end
               end
            end
            PH_READY: begin
               if (cyc_done)    idle_q <= '0;
               else if (reinit) begin
                  idle_q  <= '0;
                  phase_q <= PH_INIT;
               end else         idle_q <= idle_q + DW'(1);
            end
            default: phase_q <= PH_PAUSE;
         endcase
      end
   end

   assign phase = phase_q;

   // R2: nothing is launched during the pause
   a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PAUSE) |-> !cyc_start);
   // R3: ready is only entered on a completed init cycle
   a_r3_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == PH_READY) && ($past(phase_q) == PH_INIT)) |-> $past(cyc_done));
   // R12: an idle timeout leads back to initialization, never to the pause
   a_r12_no_second_pause: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_q) != PH_PAUSE) |-> (phase_q != PH_PAUSE));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import rfs_pkg::*;
#(
   parameter int PAUSE_CYC        = 20000,
   parameter int INIT_CYCLES      = 8,
   parameter int REF_INTERVAL_CYC = 1560,
   parameter int IDLE_LIMIT_CYC   = 800000,
   parameter int CSR_CYC          = 1,
   parameter int RAS_LOW_CYC      = 5,
   parameter int CHR_CYC          = 1,
   parameter int PRE_CYC          = 3,
   parameter int PEND_MAX         = 8,
   parameter int BURST_MODE       = 0,
   parameter int BURST_LEN        = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic ref_req,
   input  logic ref_gnt,
   output logic ras_n,
   output logic cas_lo_n,
   output logic cas_hi_n,
   output logic we_n,
   output logic init_done,
   output logic pend_ovf
);
   localparam int CYC_LEN = CSR_CYC + RAS_LOW_CYC + PRE_CYC + 1;

   generate
      if (CSR_CYC < 1 || CHR_CYC < 1 || CHR_CYC >= RAS_LOW_CYC || PRE_CYC < 1) begin : g_bad_strobe
         $error("strobe timing parameters out of range");
      end
      if (INIT_CYCLES < 1 || PAUSE_CYC < 1 || REF_INTERVAL_CYC <= CYC_LEN) begin : g_bad_seq
         $error("sequence parameters out of range");
      end
      if (BURST_MODE != 0 && (BURST_LEN < 1 || BURST_LEN > PEND_MAX)) begin : g_bad_burst
         $error("BURST_LEN must lie in 1..PEND_MAX");
      end
      if (IDLE_LIMIT_CYC <= REF_INTERVAL_CYC) begin : g_bad_idle
         $error("IDLE_LIMIT_CYC must exceed REF_INTERVAL_CYC");
      end
   endgenerate

   phase_e phase;
   logic   reinit, tick, want, pend_empty;
   logic   busy, done, ras_act, cas_act, start;
   logic   in_init, in_ready;

   assign in_init  = (phase == PH_INIT);
   assign in_ready = (phase == PH_READY);
   assign start    = ref_gnt && !busy && (in_init || (in_ready && want && !reinit));

   rfs_phase_ctl #(
      .PAUSE_CYC      (PAUSE_CYC),
      .INIT_CYCLES    (INIT_CYCLES),
      .IDLE_LIMIT_CYC (IDLE_LIMIT_CYC)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (start),
      .cyc_done  (done),
      .phase     (phase),
      .reinit    (reinit)
   );

   rfs_interval_tick #(
      .REF_INTERVAL_CYC (REF_INTERVAL_CYC)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_ready),
      .tick  (tick)
   );

   rfs_pending #(
      .PEND_MAX   (PEND_MAX),
      .BURST_MODE (BURST_MODE),
      .BURST_LEN  (BURST_LEN)
   ) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick),
      .dec   (done && in_ready),
      .clr   (reinit),
      .want  (want),
      .empty (pend_empty),
      .ovf   (pend_ovf)
   );

   rfs_cbr_gen #(
      .CSR_CYC     (CSR_CYC),
      .RAS_LOW_CYC (RAS_LOW_CYC),
      .CHR_CYC     (CHR_CYC),
      .PRE_CYC     (PRE_CYC)
   ) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .done    (done),
      .ras_act (ras_act),
      .cas_act (cas_act)
   );

   assign ref_req   = busy || in_init || (in_ready && want);
   assign ras_n     = !(ras_act && ref_gnt);
   assign cas_lo_n  = !(cas_act && ref_gnt);
   assign cas_hi_n  = !(cas_act && ref_gnt);
   assign we_n      = 1'b1;
   assign init_done = in_ready;

   // R9: the request is only withdrawn once nothing is owed
   a_r9_req_until_drained: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_req) |-> pend_empty);
   // R12: leaving ready clears the owed count
   a_r12_clear_on_reinit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_done) |-> pend_empty);
   // R3: init_done never rises while a refresh cycle is still open
   a_r3_ready_idle_gen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> !ras_act);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int P_PAUSE = 100;
   localparam int P_INIT  = 8;
   localparam int P_INT   = 60;
   localparam int P_CSR   = 2;
   localparam int P_RAS   = 4;
   localparam int P_CHR   = 2;
   localparam int P_PRE   = 3;
   localparam int P_PMAX  = 4;
   localparam int P_IDLE  = 600;
   localparam int P_BLEN  = 3;
   localparam int CYC_LEN = P_CSR + P_RAS + P_PRE + 1;
   localparam int GROUP_GAP = P_BLEN * P_INT - (P_BLEN - 1) * CYC_LEN;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b1;
   logic gnt_b = 1'b1;
   logic ref_req, ras_n, cas_lo_n, cas_hi_n, we_n, init_done, pend_ovf;
   logic ref_req_b, ras_n_b, cas_lo_n_b, cas_hi_n_b, we_n_b, init_done_b, pend_ovf_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_sched #(
      .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .REF_INTERVAL_CYC(P_INT),
      .IDLE_LIMIT_CYC(P_IDLE), .CSR_CYC(P_CSR), .RAS_LOW_CYC(P_RAS),
      .CHR_CYC(P_CHR), .PRE_CYC(P_PRE), .PEND_MAX(P_PMAX),
      .BURST_MODE(0), .BURST_LEN(P_BLEN)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(gnt),
      .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n),
      .init_done(init_done), .pend_ovf(pend_ovf)
   );

   dram_refresh_sched #(
      .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .REF_INTERVAL_CYC(P_INT),
      .IDLE_LIMIT_CYC(P_IDLE), .CSR_CYC(P_CSR), .RAS_LOW_CYC(P_RAS),
      .CHR_CYC(P_CHR), .PRE_CYC(P_PRE), .PEND_MAX(P_PMAX),
      .BURST_MODE(1), .BURST_LEN(P_BLEN)
   ) u_dut_burst (
      .clk(clk), .rst_n(rst_n), .ref_req(ref_req_b), .ref_gnt(gnt_b),
      .ras_n(ras_n_b), .cas_lo_n(cas_lo_n_b), .cas_hi_n(cas_hi_n_b), .we_n(we_n_b),
      .init_done(init_done_b), .pend_ovf(pend_ovf_b)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // strobe monitor, distributed instance
   int  cyc = 0, falls = 0, first_fall = -1;
   int  cas_run = 0, ras_low_run = 0, cas_hold = 0, ras_high_run = 0;
   bit  prev_ras = 1'b1;
   int  inv_we = 0, inv_pair = 0, inv_gnt = 0, inv_early = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (we_n !== 1'b1 || we_n_b !== 1'b1) inv_we++;
         if (cas_lo_n !== cas_hi_n || cas_lo_n_b !== cas_hi_n_b) inv_pair++;
         if (!gnt && (ras_n !== 1'b1 || cas_lo_n !== 1'b1 || cas_hi_n !== 1'b1)) inv_gnt++;
         if (init_done && falls < P_INIT) inv_early++;
         if (prev_ras && !ras_n) begin
            chk(!cas_lo_n, "R4 cas low at ras fall", cas_lo_n, 0);
            chk(cas_run == P_CSR, "R4 cas setup cycles", cas_run, P_CSR);
            if (falls > 0) chk(ras_high_run >= P_PRE + P_CSR, "R5 ras high between cycles", ras_high_run, P_PRE + P_CSR);
            else first_fall = cyc;
            falls++;
            ras_low_run = 1;
            cas_hold = cas_lo_n ? 0 : 1;
         end else if (!prev_ras && ras_n) begin
            chk(ras_low_run == P_RAS, "R5 ras low width", ras_low_run, P_RAS);
            chk(cas_hold == P_CHR, "R4 cas hold after ras fall", cas_hold, P_CHR);
            ras_high_run = 1;
            cas_run = 0;
         end else if (!ras_n) begin
            ras_low_run++;
            if (!cas_lo_n) cas_hold++;
         end else begin
            ras_high_run++;
            if (!cas_lo_n) cas_run++;
            else cas_run = 0;
         end
         prev_ras = ras_n;
      end
   end

   // RAS fall spacing monitor, grouped instance
   int bcyc = 0, bfalls = 0, blast = 0, bgaps = 0;
   bit bprev = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         bcyc++;
         if (bprev && !ras_n_b) begin
            if (bfalls > P_INIT) begin
               bgaps++;
               chk((bcyc - blast == CYC_LEN) || (bcyc - blast == GROUP_GAP),
                   "R11 grouped ras fall spacing", bcyc - blast, GROUP_GAP);
            end
            bfalls++;
            blast = bcyc;
         end
         bprev = ras_n_b;
      end
   end

   task automatic wait_init();
      for (int n = 0; n < 3000 && !init_done; n++) @(posedge clk);
      #1;
   endtask

   task automatic align_on_fall();
      int f;
      f = falls;
      for (int n = 0; n < 500 && falls == f; n++) @(posedge clk);
      repeat (10) @(posedge clk);
      #1;
   endtask

   int f0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(ras_n && cas_lo_n && cas_hi_n && we_n, "R1 strobes high in reset",
          {ras_n, cas_lo_n, cas_hi_n, we_n}, 15);
      chk(!ref_req && !init_done && !pend_ovf, "R1 flags low in reset",
          {ref_req, init_done, pend_ovf}, 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2, R3: pause and initialization burst
      wait_init();
      chk(init_done, "R3 init_done raised", init_done, 1);
      chk(falls == P_INIT, "R3 init burst length", falls, P_INIT);
      chk(inv_early == 0, "R3 init_done early", inv_early, 0);
      chk(first_fall >= P_PAUSE && first_fall <= P_PAUSE + 6, "R2 first ras fall after pause", first_fall, P_PAUSE + 4);
      chk(init_done_b, "R3 grouped instance ready", init_done_b, 1);

      // R11: grouped instance does not request for a single owed refresh
      repeat (P_INT + 5) @(posedge clk); #1;
      chk(!ref_req_b, "R11 no request below group size", ref_req_b, 0);

      // R7: one refresh per interval
      f0 = falls;
      repeat (10 * P_INT) @(posedge clk); #1;
      chk(falls - f0 == 10, "R7 refreshes per 10 intervals", falls - f0, 10);

      // R9: two owed refreshes drained after grant
      align_on_fall();
      gnt = 1'b0;
      f0 = falls;
      repeat (120) @(posedge clk); #1;
      chk(ref_req, "R9 request while owed", ref_req, 1);
      chk(falls == f0, "R8 no refresh without grant", falls - f0, 0);
      chk(!pend_ovf, "R10 no overflow yet", pend_ovf, 0);
      gnt = 1'b1;
      repeat (35) @(posedge clk); #1;
      chk(falls - f0 == 2, "R9 owed cycles drained", falls - f0, 2);
      chk(!ref_req, "R9 request dropped after drain", ref_req, 0);

      // R10: saturation and sticky overflow
      align_on_fall();
      gnt = 1'b0;
      repeat (360) @(posedge clk); #1;
      chk(pend_ovf, "R10 overflow flagged", pend_ovf, 1);
      chk(ref_req, "R9 request during long hold", ref_req, 1);
      gnt = 1'b1;
      f0 = falls;
      repeat (43) @(posedge clk); #1;
      chk(falls - f0 == P_PMAX, "R10 drained count equals cap", falls - f0, P_PMAX);
      chk(!ref_req, "R9 request dropped after capped drain", ref_req, 0);
      chk(pend_ovf, "R10 overflow sticky", pend_ovf, 1);

      // R12: idle timeout re-initialization
      align_on_fall();
      gnt = 1'b0;
      repeat (700) @(posedge clk); #1;
      chk(!init_done, "R12 init_done dropped after idle", init_done, 0);
      chk(ref_req, "R12 request for re-init", ref_req, 1);
      f0 = falls;
      gnt = 1'b1;
      wait_init();
      chk(falls - f0 == P_INIT, "R12 re-init burst length", falls - f0, P_INIT);
      repeat (5) @(posedge clk); #1;
      chk(!ref_req, "R12 owed count cleared", ref_req, 0);

      // invariants collected over the run
      chk(inv_we == 0, "R6 we_n held high", inv_we, 0);
      chk(inv_pair == 0, "R4 cas lines identical", inv_pair, 0);
      chk(inv_gnt == 0, "R8 strobes idle without grant", inv_gnt, 0);
      chk(bgaps >= 6, "R11 grouped spacings observed", bgaps, 6);
      chk(!pend_ovf_b, "R10 grouped instance no overflow", pend_ovf_b, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule